// File: doc/BRIEF.md
# Cross-Domain Timer Register Bridge

This block lets a processor running on a fast clock program a small timer that counts on a slow, free-running oscillator clock. It has five writable registers: the counter, two compare values and two control words. A write from the processor never goes straight to the timer. It is parked in a holding register that belongs to that one register. A toggle request then carries it across to the oscillator domain, and the value is committed there. Each register has its own busy bit. The bit is raised by the write and dropped only when the commit has been acknowledged back in the processor domain. Software polls the bit before it writes that register again. A write that arrives while the bit is still set is dropped and reported with a one-cycle reject pulse.

The counter runs in the oscillator domain behind a power-of-two prescaler. It can wrap freely, or it can be cleared when it reaches the first compare value. Each compare value drives a one-oscillator-cycle match pulse. A reading of the counter by the processor returns a snapshot. That snapshot is captured in the oscillator domain and handed over through a handshake, so it is always a value the counter really held. The processor clock must be more than four times the oscillator clock. Each domain has its own synchronous active-high reset, and the two resets are applied together.

Top module: `async_tmr_bridge`

## Requirements
- R1: After reset, the busy bits are all 0, wrReject and both match outputs are 0, and a read at address 0 (counter) returns 0.
- R2: A write with wrEn to address 0 (counter), 1 (compare A), 2 (compare B), 3 (control A) or 4 (control B) whose busy bit is clear loads that register's holding register. It also sets busy bit i, which is bit i of the busy port and bit i of the status read at address 5. Both effects are visible from the next processor cycle. For addresses 1 to 4, a read at the same address returns the holding value.
- R3: A busy bit stays set for at least two rising oscillator edges after its write. It clears by itself within three oscillator periods plus four processor cycles. After it clears, the value is in effect in the oscillator domain.
- R4: A write to a register whose busy bit is set is ignored: the holding value and the final committed value keep the first write. For that write, wrReject is 1 in the next processor cycle, and only in that cycle.
- R5: Pending commits to different registers are independent. A write to one register while another is busy is accepted without a reject, and both values are committed.
- R6: Control A bit 0 enables counting, and bit 1 selects clear-on-compare-A. Control B bits [1:0] = n make the counter advance once every 2^n oscillator cycles. With counting disabled, the counter holds its value and no match pulse occurs.
- R7: With clear-on-compare-A, the counter steps 0 up to compare A and then returns to 0 on the next step. matchA is a one-oscillator-cycle pulse on each step taken while the counter equals compare A, so pulses are (compareA+1)·2^n oscillator cycles apart.
- R8: Without clear-on-compare-A, the counter wraps at 2^DW, so matchA pulses are 2^DW steps apart. In either mode, matchB pulses on each step taken while the counter equals compare B, and it does not clear the counter.
- R9: A read at address 0 returns a coherent snapshot of the counter. Once the counter is stopped and a new counter value has been committed, reads return exactly that value.
- R10: Writes to addresses 5 to 7 are ignored. They set no busy bit and raise no wrReject.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| cpuClk | input | 1 | Processor clock |
| cpuRst | input | 1 | Synchronous active-high reset, processor domain |
| oscClk | input | 1 | Slow oscillator clock for the timer |
| oscRst | input | 1 | Synchronous active-high reset, oscillator domain |
| wrEn | input | 1 | Write strobe, processor domain |
| wrAddr | input | AW (3) | Write address |
| wrData | input | DW (8) | Write data |
| rdAddr | input | AW (3) | Read address (0 counter, 1 to 4 holding values, 5 busy status) |
| rdData | output | DW (8) | Read data, combinational from rdAddr |
| busy | output | 5 | Per-register commit-pending bits |
| wrReject | output | 1 | One-cycle pulse: write ignored because the register was busy |
| matchA | output | 1 | Compare A match pulse, oscillator domain |
| matchB | output | 1 | Compare B match pulse, oscillator domain |

## Verification
The holding readback, the busy bit and the reject pulse are registered on the processor clock. The bench samples them at the falling edge right after the rising edge that took the write. A busy bit is expected to clear between 8 and 30 processor cycles after its write. That range follows from three synchronizer stages at a 58 ns oscillator period against a 10 ns processor period. The bench measures the actual count and checks it against that window. Match pulses are measured in oscillator cycles between consecutive pulses, sampled on the oscillator's falling edge. Counter snapshots are read only after 60 or more processor cycles, well past a full handshake round.

// File: rtl/tmr_bridge_pkg.sv
package tmr_bridge_pkg;
  localparam int NumRegs = 5;
  localparam int RegCnt  = 0;
  localparam int RegCmpA = 1;
  localparam int RegCmpB = 2;
  localparam int RegCtlA = 3;
  localparam int RegCtlB = 4;
  localparam int RegStat = 5;

  // processor domain to oscillator domain: toggle strobes
  typedef struct packed {
    logic [NumRegs-1:0] reqTgl;
    logic               snapReq;
  } cpu2osc_t;

  // oscillator domain to processor domain: acknowledge toggles
  typedef struct packed {
    logic [NumRegs-1:0] ackTgl;
    logic               snapAck;
  } osc2cpu_t;
endpackage

// File: rtl/tmr_cpu_side.sv
module tmr_cpu_side
  import tmr_bridge_pkg::*;
#(
  parameter int DW = 8,
  parameter int AW = 3
) (
  input  logic                  cpuClk,
  input  logic                  cpuRst,
  input  logic                  wrEn,
  input  logic [AW-1:0]         wrAddr,
  input  logic [DW-1:0]         wrData,
  input  logic [AW-1:0]         rdAddr,
  input  osc2cpu_t              fromOsc,
  input  logic [DW-1:0]         oscSnap,
  output cpu2osc_t              toOsc,
  output logic [NumRegs*DW-1:0] holdFlat,
  output logic [NumRegs-1:0]    busy,
  output logic                  wrReject,
  output logic [DW-1:0]         rdData
);
  logic [DW-1:0]      holdReg [NumRegs];
  logic [NumRegs-1:0] reqTgl;
  logic [NumRegs-1:0] ackS1, ackS2;
  logic [NumRegs-1:0] hitVec;
  logic               snapReq, snapS1, snapS2;
  logic [DW-1:0]      cpuCnt;

  assign busy = reqTgl ^ ackS2;

  genvar i;
  generate
    for (i = 0; i < NumRegs; i++) begin : g_reg
      assign hitVec[i] = wrEn && (wrAddr == AW'(i));
      assign holdFlat[i*DW +: DW] = holdReg[i];

      always_ff @(posedge cpuClk) begin
        if (cpuRst) begin
          holdReg[i] <= '0;
          reqTgl[i]  <= 1'b0;
        end else if (hitVec[i] && !busy[i]) begin
          holdReg[i] <= wrData;
          reqTgl[i]  <= ~reqTgl[i];
        end
      end
    end
  endgenerate

  always_ff @(posedge cpuClk) begin
    if (cpuRst) begin
      ackS1    <= '0;
      ackS2    <= '0;
      wrReject <= 1'b0;
    end else begin
      ackS1    <= fromOsc.ackTgl;
      ackS2    <= ackS1;
      wrReject <= |(hitVec & busy);
    end
  end

  // free-running snapshot handshake for coherent counter reads
  always_ff @(posedge cpuClk) begin
    if (cpuRst) begin
      snapS1  <= 1'b0;
      snapS2  <= 1'b0;
      snapReq <= 1'b0;
      cpuCnt  <= '0;
    end else begin
      snapS1 <= fromOsc.snapAck;
      snapS2 <= snapS1;
      if (snapS2 == snapReq) begin
        cpuCnt  <= oscSnap;
        snapReq <= ~snapReq;
      end
    end
  end

  assign toOsc.reqTgl  = reqTgl;
  assign toOsc.snapReq = snapReq;

  always_comb begin
    rdData = '0;
    for (int k = 0; k < NumRegs; k++)
      if (rdAddr == AW'(k)) rdData = holdReg[k];
    if (rdAddr == AW'(RegCnt))  rdData = cpuCnt;
    if (rdAddr == AW'(RegStat)) rdData = DW'(busy);
  end
endmodule

// File: rtl/tmr_osc_side.sv
module tmr_osc_side
  import tmr_bridge_pkg::*;
#(
  parameter int DW     = 8,
  parameter int PsSelW = 2
) (
  input  logic                  oscClk,
  input  logic                  oscRst,
  input  cpu2osc_t              fromCpu,
  input  logic [NumRegs*DW-1:0] holdFlat,
  output osc2cpu_t              toCpu,
  output logic [DW-1:0]         snap,
  output logic                  matchA,
  output logic                  matchB,
  output logic [DW-1:0]         cntVal,
  output logic                  ctcMode
);
  localparam int PsCntW = (2 ** PsSelW) - 1;

  logic [NumRegs-1:0] reqS1, reqS2, ackTgl, commit;
  logic [DW-1:0]      cnt, cmpA, cmpB, ctlA, ctlB;
  logic [PsCntW-1:0]  psCnt, psMask;
  logic               tick, snapS1, snapS2, snapAck;

  always_ff @(posedge oscClk) begin
    if (oscRst) begin
      reqS1  <= '0;
      reqS2  <= '0;
      ackTgl <= '0;
    end else begin
      reqS1  <= fromCpu.reqTgl;
      reqS2  <= reqS1;
      ackTgl <= reqS2;
    end
  end

  assign commit = reqS2 ^ ackTgl;

  always_ff @(posedge oscClk) begin
    if (oscRst) begin
      cmpA <= '0;
      cmpB <= '0;
      ctlA <= '0;
      ctlB <= '0;
    end else begin
      if (commit[RegCmpA]) cmpA <= holdFlat[RegCmpA*DW +: DW];
      if (commit[RegCmpB]) cmpB <= holdFlat[RegCmpB*DW +: DW];
      if (commit[RegCtlA]) ctlA <= holdFlat[RegCtlA*DW +: DW];
      if (commit[RegCtlB]) ctlB <= holdFlat[RegCtlB*DW +: DW];
    end
  end

  assign ctcMode = ctlA[1];

  always_comb begin
    for (int k = 0; k < PsCntW; k++)
      psMask[k] = (k < int'(ctlB[PsSelW-1:0]));
  end

  assign tick = ctlA[0] && ((psCnt & psMask) == psMask);

  always_ff @(posedge oscClk) begin
    if (oscRst) begin
      psCnt  <= '0;
      cnt    <= '0;
      matchA <= 1'b0;
      matchB <= 1'b0;
    end else begin
      psCnt  <= psCnt + 1'b1;
      matchA <= tick && (cnt == cmpA);
      matchB <= tick && (cnt == cmpB);
      if (commit[RegCnt])
        cnt <= holdFlat[RegCnt*DW +: DW];
      else if (tick)
        cnt <= (ctcMode && (cnt == cmpA)) ? '0 : cnt + 1'b1;
    end
  end

  always_ff @(posedge oscClk) begin
    if (oscRst) begin
      snapS1  <= 1'b0;
      snapS2  <= 1'b0;
      snapAck <= 1'b0;
      snap    <= '0;
    end else begin
      snapS1 <= fromCpu.snapReq;
      snapS2 <= snapS1;
      if (snapS2 != snapAck) begin
        snap    <= cnt;
        snapAck <= snapS2;
      end
    end
  end

  logic unusedCtl;
  assign unusedCtl = ^{ctlA[DW-1:2], ctlB[DW-1:PsSelW]};

  assign toCpu.ackTgl  = ackTgl;
  assign toCpu.snapAck = snapAck;
  assign cntVal        = cnt;
endmodule

// File: rtl/async_tmr_bridge.sv
module async_tmr_bridge
  import tmr_bridge_pkg::*;
#(
  parameter int DW     = 8,
  parameter int AW     = 3,
  parameter int PsSelW = 2
) (
  input  logic          cpuClk,
  input  logic          cpuRst,
  input  logic          oscClk,
  input  logic          oscRst,
  input  logic          wrEn,
  input  logic [AW-1:0] wrAddr,
  input  logic [DW-1:0] wrData,
  input  logic [AW-1:0] rdAddr,
  output logic [DW-1:0] rdData,
  output logic [4:0]    busy,
  output logic          wrReject,
  output logic          matchA,
  output logic          matchB
);
  cpu2osc_t              toOsc;
  osc2cpu_t              toCpu;
  logic [NumRegs*DW-1:0] holdFlat;
  logic [DW-1:0]         oscSnap;
  logic [DW-1:0]         cntVal;
  logic                  ctcMode;

  tmr_cpu_side #(.DW(DW), .AW(AW)) cpu_i (
    .cpuClk(cpuClk), .cpuRst(cpuRst),
    .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData), .rdAddr(rdAddr),
    .fromOsc(toCpu), .oscSnap(oscSnap),
    .toOsc(toOsc), .holdFlat(holdFlat),
    .busy(busy), .wrReject(wrReject), .rdData(rdData)
  );

  tmr_osc_side #(.DW(DW), .PsSelW(PsSelW)) osc_i (
    .oscClk(oscClk), .oscRst(oscRst),
    .fromCpu(toOsc), .holdFlat(holdFlat),
    .toCpu(toCpu), .snap(oscSnap),
    .matchA(matchA), .matchB(matchB),
    .cntVal(cntVal), .ctcMode(ctcMode)
  );
endmodule

// File: rtl/tmr_bridge_chk.sv
module tmr_bridge_chk
  import tmr_bridge_pkg::*;
#(
  parameter int DW = 8,
  parameter int AW = 3
) (
  input logic                  cpuClk,
  input logic                  cpuRst,
  input logic                  oscClk,
  input logic                  oscRst,
  input logic                  wrEn,
  input logic [AW-1:0]         wrAddr,
  input logic [4:0]            busy,
  input logic                  wrReject,
  input logic [NumRegs*DW-1:0] holdFlat,
  input logic                  matchA,
  input logic [DW-1:0]         cntVal,
  input logic                  ctcMode
);
  genvar i;
  generate
    for (i = 0; i < NumRegs; i++) begin : g_chk
      // R2 R10
      busy_rise_chk: assert property (@(posedge cpuClk) disable iff (cpuRst)
        $rose(busy[i]) |-> $past(wrEn && (wrAddr == AW'(i))));

      // R4
      hold_stable_chk: assert property (@(posedge cpuClk) disable iff (cpuRst)
        $past(busy[i]) |-> $stable(holdFlat[i*DW +: DW]));
    end
  endgenerate

  // R4
  reject_cause_chk: assert property (@(posedge cpuClk) disable iff (cpuRst)
    wrReject |-> ($past(wrEn) && ($past(busy) != '0)));

  // R4
  reject_pulse_chk: assert property (@(posedge cpuClk) disable iff (cpuRst)
    wrReject |=> !wrReject || $past(wrEn));

  // R7
  ctc_clear_chk: assert property (@(posedge oscClk) disable iff (oscRst)
    (matchA && ctcMode && $past(ctcMode)) |-> (cntVal == '0));
endmodule

bind async_tmr_bridge tmr_bridge_chk #(.DW(DW), .AW(AW)) chk_i (
  .cpuClk(cpuClk), .cpuRst(cpuRst), .oscClk(oscClk), .oscRst(oscRst),
  .wrEn(wrEn), .wrAddr(wrAddr), .busy(busy), .wrReject(wrReject),
  .holdFlat(holdFlat), .matchA(matchA), .cntVal(cntVal), .ctcMode(ctcMode)
);

// File: tb/async_tmr_bridge_tb_top.sv
module async_tmr_bridge_tb_top;
  logic       cpuClk = 1'b0;
  logic       oscClk = 1'b0;
  logic       cpuRst = 1'b1;
  logic       oscRst = 1'b1;
  logic       wrEn   = 1'b0;
  logic [2:0] wrAddr = '0;
  logic [7:0] wrData = '0;
  logic [2:0] rdAddr = '0;
  logic [7:0] rdData;
  logic [4:0] busy;
  logic       wrReject, matchA, matchB;

  int checks   = 0;
  int failures = 0;

  always #5 cpuClk = ~cpuClk;
  initial begin
    #3;
    forever #29 oscClk = ~oscClk;
  end

  async_tmr_bridge dut_i (
    .cpuClk(cpuClk), .cpuRst(cpuRst), .oscClk(oscClk), .oscRst(oscRst),
    .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData), .rdAddr(rdAddr),
    .rdData(rdData), .busy(busy), .wrReject(wrReject),
    .matchA(matchA), .matchB(matchB)
  );

  task automatic check(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic checkRange(input string req, input string what, input int act,
                            input int lo, input int hi);
    checks++;
    if (act < lo || act > hi) begin
      failures++;
      $display("FAIL %s %s actual=%0d expected=%0d..%0d", req, what, act, lo, hi);
    end
  endtask

  task automatic doWrite(input int a, input int d);
    @(negedge cpuClk);
    wrEn = 1'b1; wrAddr = 3'(a); wrData = 8'(d);
    @(negedge cpuClk);
    wrEn = 1'b0;
  endtask

  task automatic readReg(input int a, output int v);
    rdAddr = 3'(a);
    #1;
    v = int'(rdData);
  endtask

  task automatic waitIdle();
    for (int n = 0; n < 200; n++) begin
      if (busy == '0) break;
      @(negedge cpuClk);
    end
  endtask

  task automatic measurePeriod(input bit useB, output int p);
    p = 0;
    for (int n = 0; n < 1200; n++) begin
      @(negedge oscClk);
      if ((useB ? matchB : matchA) == 1'b1) break;
    end
    for (int n = 0; n < 1200; n++) begin
      @(negedge oscClk);
      p++;
      if ((useB ? matchB : matchA) == 1'b1) break;
    end
  endtask

  task automatic t_reset();
    int v;
    check("R1", "busy after reset", int'(busy), 0);
    check("R1", "wrReject after reset", int'(wrReject), 0);
    check("R1", "match outputs after reset", int'({matchA, matchB}), 0);
    readReg(0, v);
    check("R1", "counter read after reset", v, 0);
  endtask

  task automatic t_writeBusy();
    int v, n;
    doWrite(1, 5);
    check("R2", "busy after compare A write", int'(busy), 2);
    readReg(1, v);
    check("R2", "compare A holding readback", v, 5);
    readReg(5, v);
    check("R2", "status read busy bit", v, 2);
    n = 0;
    while (busy[1] && n < 100) begin
      @(negedge cpuClk);
      n++;
    end
    checkRange("R3", "cycles until busy clears", n, 8, 30);
  endtask

  task automatic t_reject();
    int v;
    doWrite(2, 3);
    doWrite(2, 9);
    check("R4", "reject pulse on busy write", int'(wrReject), 1);
    @(negedge cpuClk);
    check("R4", "reject pulse lasts one cycle", int'(wrReject), 0);
    readReg(2, v);
    check("R4", "holding value kept", v, 3);
    waitIdle();
    readReg(2, v);
    check("R4", "committed value kept", v, 3);
  endtask

  task automatic t_independent();
    int v;
    doWrite(0, 16);
    doWrite(4, 0);
    check("R5", "no reject across registers", int'(wrReject), 0);
    check("R5", "two busy bits pending", int'(busy), 17);
    waitIdle();
    check("R5", "both commits done", int'(busy), 0);
    repeat (80) @(negedge cpuClk);
    readReg(0, v);
    check("R5", "counter committed", v, 16);
  endtask

  task automatic t_unmapped();
    int v;
    doWrite(6, 255);
    check("R10", "no reject for unmapped write", int'(wrReject), 0);
    check("R10", "no busy for unmapped write", int'(busy), 0);
    readReg(1, v);
    check("R10", "compare A unchanged", v, 5);
  endtask

  task automatic t_ctc();
    int p;
    doWrite(3, 3);
    waitIdle();
    measurePeriod(1'b0, p);
    check("R7", "matchA period, compare 5, prescale 1", p, 6);
    measurePeriod(1'b1, p);
    check("R8", "matchB period inside compare-A clear cycle", p, 6);
  endtask

  task automatic t_prescale();
    int p;
    doWrite(4, 1);
    waitIdle();
    measurePeriod(1'b0, p);
    check("R6", "matchA period with prescale 2", p, 12);
    doWrite(4, 2);
    waitIdle();
    measurePeriod(1'b0, p);
    check("R6", "matchA period with prescale 4", p, 24);
    doWrite(4, 0);
    waitIdle();
  endtask

  task automatic t_freeRun();
    int p;
    doWrite(3, 1);
    waitIdle();
    measurePeriod(1'b0, p);
    check("R8", "free-run wrap period", p, 256);
  endtask

  task automatic t_read();
    int v, seen;
    doWrite(3, 0);
    waitIdle();
    doWrite(0, 66);
    waitIdle();
    repeat (60) @(negedge cpuClk);
    readReg(0, v);
    check("R9", "stopped counter snapshot", v, 66);
    seen = 0;
    for (int n = 0; n < 30; n++) begin
      @(negedge oscClk);
      if (matchA || matchB) seen++;
    end
    check("R6", "no match while disabled", seen, 0);
    readReg(0, v);
    check("R9", "counter holds while disabled", v, 66);
  endtask

  initial begin
    repeat (5) @(negedge oscClk);
    @(negedge cpuClk);
    cpuRst = 1'b0;
    oscRst = 1'b0;
    @(negedge cpuClk);
    t_reset();
    t_writeBusy();
    t_reject();
    t_independent();
    t_unmapped();
    t_ctc();
    t_prescale();
    t_freeRun();
    t_read();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge cpuClk);
    failures++;
    $display("FAIL watchdog run hung actual=timeout expected=completion");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule